// File: doc/BRIEF.md
# Level- and Edge-Aware Interrupt Collector

This block gathers up to 32 interrupt request lines into one registered interrupt line for a processor. Each line is fixed at build time as edge-sensitive or level-sensitive through a per-line mask parameter. A captured request is held in a status word until software clears it. Software reaches the status, enable, acknowledge and master-control words through a simple synchronous read/write bus.

A hardware-enable bit in the master-control word decides who owns the status word. While it is set, the pins own the status word: edges and high levels set bits, and direct software writes to the status word are ignored. While it is clear, the pins cannot change status and software may write the status word directly. A level line that is still high sets its bit again on the cycle after an acknowledge, so an acknowledge cannot clear it. A line going low never clears a bit.

Top module: `intr_hub`

## Requirements
- R1: After reset, the status, enable and master-control words read 0 and `irq_out` is low.
- R2: The byte offsets are status 0x00, enable 0x08, acknowledge 0x0C and master-control 0x1C. Read data appears on `bus_rdata` after the clock edge that samples `bus_rd_en`. The acknowledge offset and unmapped offsets read 0. Status and enable bits at or above `N_SRC` read 0 and cannot be written.
- R3: While master-control bit 1 (hardware enable) is 0, a write to the status offset replaces the status word, and pin activity changes no status bit.
- R4: While master-control bit 1 is 1, a write to the status offset has no effect on the status word.
- R5: For an edge line, with hardware enable set, a pin that is high in a cycle and was low in the previous cycle sets its status bit at that clock edge. A pin that stays high does not set the bit again after an acknowledge.
- R6: For a level line, with hardware enable set, a high pin sets its status bit at every clock edge. An acknowledge given while the pin is high clears the bit for one cycle only, and the bit is set again at the next edge.
- R7: A pin going low never clears a status bit.
- R8: Writing 1s to the acknowledge offset clears those status bits at that edge. An edge that arrives on a line in the same cycle as that line's acknowledge leaves the bit set.
- R9: `irq_out` is set one clock after master-control bit 0 is 1 and (status AND enable) is nonzero, and is low one clock after either condition stops holding.
- R10: Clearing master-control bit 1 does not, by itself, lower `irq_out` or clear status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | N_SRC | Interrupt request lines |
| irq_out | output | 1 | Registered interrupt line to the processor |

## Verification
A bus write or a pin change applied before edge k shows in the status word at edge k. `irq_out` follows at edge k+1, and a read strobed before edge j returns its data after edge j. The bench drives inputs just after a rising edge and samples on the falling edge. Read checks go through a queue that is popped on the falling edge after the sampling edge. Output checks wait two full clocks after the stimulus, so every register on the path has updated. The ordering cases (an acknowledge while a level line is high, an edge together with its own acknowledge) are set up in a single cycle and read back after it.

// File: rtl/ih_pkg.sv
package ih_pkg;
  localparam int BUS_W = 32;
  localparam logic [7:0] OFF_STAT = 8'h00;
  localparam logic [7:0] OFF_ENAB = 8'h08;
  localparam logic [7:0] OFF_ACK  = 8'h0C;
  localparam logic [7:0] OFF_CTRL = 8'h1C;
  localparam int CTRL_ME_BIT  = 0;
  localparam int CTRL_HWE_BIT = 1;
endpackage

// File: rtl/ih_pin_detect.sv
module ih_pin_detect #(
  parameter int N_SRC = 32,
  parameter logic [N_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pins,
  input  logic             hw_en,
  output logic [N_SRC-1:0] edge_hit,
  output logic [N_SRC-1:0] level_hit
);
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] prev_d;

  always_comb begin
    prev_d = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_line
    if (LEVEL_MASK[i]) begin : g_level
      assign level_hit[i] = hw_en & pins[i];
      assign edge_hit[i]  = 1'b0;
    end else begin : g_edge
      assign edge_hit[i]  = hw_en & pins[i] & ~prev_q[i];
      assign level_hit[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ih_bus_regs.sv
module ih_bus_regs
  import ih_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [N_SRC-1:0]  stat_q,
  output logic [N_SRC-1:0]  enab_q,
  output logic              me_q,
  output logic              hwe_q,
  output logic              stat_wr,
  output logic [N_SRC-1:0]  stat_wdata,
  output logic [N_SRC-1:0]  ack_mask,
  output logic [BUS_W-1:0]  rdata
);
  logic sel_stat, sel_enab, sel_ack, sel_ctrl;
  logic [N_SRC-1:0] enab_d;
  logic             me_d, hwe_d;
  logic [BUS_W-1:0] rdata_d;
  logic unused_wdata_bits;

  function automatic logic [BUS_W-1:0] widen(input logic [N_SRC-1:0] v);
    logic [BUS_W-1:0] r;
    r = '0;
    r[N_SRC-1:0] = v;
    return r;
  endfunction

  assign sel_stat = (addr == OFF_STAT[ADDR_W-1:0]);
  assign sel_enab = (addr == OFF_ENAB[ADDR_W-1:0]);
  assign sel_ack  = (addr == OFF_ACK[ADDR_W-1:0]);
  assign sel_ctrl = (addr == OFF_CTRL[ADDR_W-1:0]);

  assign unused_wdata_bits = ^wdata;

  assign stat_wr    = wr_en & sel_stat & ~hwe_q;
  assign stat_wdata = wdata[N_SRC-1:0];
  assign ack_mask   = (wr_en && sel_ack) ? wdata[N_SRC-1:0] : '0;

  always_comb begin
    enab_d = enab_q;
    me_d   = me_q;
    hwe_d  = hwe_q;
    if (wr_en && sel_enab) enab_d = wdata[N_SRC-1:0];
    if (wr_en && sel_ctrl) begin
      me_d  = wdata[CTRL_ME_BIT];
      hwe_d = wdata[CTRL_HWE_BIT];
    end
  end

  always_comb begin
    rdata_d = rdata;
    if (rd_en) begin
      if (sel_stat)      rdata_d = widen(stat_q);
      else if (sel_enab) rdata_d = widen(enab_q);
      else if (sel_ctrl) begin
        rdata_d = '0;
        rdata_d[CTRL_ME_BIT]  = me_q;
        rdata_d[CTRL_HWE_BIT] = hwe_q;
      end
      else               rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enab_q <= '0;
      me_q   <= 1'b0;
      hwe_q  <= 1'b0;
      rdata  <= '0;
    end else begin
      enab_q <= enab_d;
      me_q   <= me_d;
      hwe_q  <= hwe_d;
      rdata  <= rdata_d;
    end
  end
endmodule

// File: rtl/ih_status.sv
module ih_status #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stat_wr,
  input  logic [N_SRC-1:0] stat_wdata,
  input  logic [N_SRC-1:0] ack_mask,
  input  logic [N_SRC-1:0] edge_hit,
  input  logic [N_SRC-1:0] level_hit,
  output logic [N_SRC-1:0] stat_q
);
  logic [N_SRC-1:0] stat_d;

  always_comb begin
    if (stat_wr) stat_d = stat_wdata;
    else         stat_d = (stat_q & ~ack_mask) | edge_hit | (level_hit & ~ack_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/ih_irq_out.sv
module ih_irq_out #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             me,
  input  logic [N_SRC-1:0] stat_q,
  input  logic [N_SRC-1:0] enab_q,
  output logic             irq_q
);
  logic irq_d;

  always_comb begin
    irq_d = me & (|(stat_q & enab_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/intr_hub.sv
module intr_hub
  import ih_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 5,
  parameter logic [N_SRC-1:0] LEVEL_MASK = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_SRC-1:0]  src_in,
  output logic              irq_out
);
  logic [N_SRC-1:0] stat_q, enab_q, stat_wdata, ack_mask, edge_hit, level_hit;
  logic             me_q, hwe_q, stat_wr;

  ih_bus_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .stat_q(stat_q), .enab_q(enab_q),
    .me_q(me_q), .hwe_q(hwe_q), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .ack_mask(ack_mask), .rdata(bus_rdata)
  );

  ih_pin_detect #(.N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_pins (
    .clk(clk), .rst_n(rst_n), .pins(src_in), .hw_en(hwe_q),
    .edge_hit(edge_hit), .level_hit(level_hit)
  );

  ih_status #(.N_SRC(N_SRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .ack_mask(ack_mask), .edge_hit(edge_hit), .level_hit(level_hit),
    .stat_q(stat_q)
  );

  ih_irq_out #(.N_SRC(N_SRC)) u_out (
    .clk(clk), .rst_n(rst_n), .me(me_q), .stat_q(stat_q), .enab_q(enab_q),
    .irq_q(irq_out)
  );
endmodule

// File: rtl/intr_hub_chk.sv
module intr_hub_chk
  import ih_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 5,
  parameter logic [N_SRC-1:0] LVL = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N_SRC-1:0]  src_in,
  input logic [N_SRC-1:0]  stat_q,
  input logic [N_SRC-1:0]  enab_q,
  input logic              me_q,
  input logic              hwe_q,
  input logic [31:0]       rdata,
  input logic              irq_out
);
  logic at_stat, at_ack;
  assign at_stat = (addr == OFF_STAT[ADDR_W-1:0]);
  assign at_ack  = (addr == OFF_ACK[ADDR_W-1:0]);

  // R9
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(me_q && (|(stat_q & enab_q)))));

  // R4
  hwe_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hwe_q && wr_en && at_stat) |=> (((stat_q & ~$past(stat_q)) & ~$past(src_in)) == '0));

  // R3
  pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hwe_q && !(wr_en && at_stat)) |=> ((stat_q & ~$past(stat_q)) == '0));

  // R7
  no_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (at_stat || at_ack))) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R6
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hwe_q && !(wr_en && at_ack)) |=> ((stat_q & LVL & $past(src_in)) == (LVL & $past(src_in))));

  // R2
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && at_ack) |=> (rdata == 32'h0));
endmodule

bind intr_hub intr_hub_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .LVL(LEVEL_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .rd_en(bus_rd_en), .addr(bus_addr),
  .src_in(src_in), .stat_q(stat_q), .enab_q(enab_q), .me_q(me_q), .hwe_q(hwe_q),
  .rdata(bus_rdata), .irq_out(irq_out)
);

// File: tb/intr_hub_tb.sv
`timescale 1ns/1ps
module intr_hub_tb;
  localparam int N = 8;
  localparam logic [N-1:0] LVL = 8'hF0;
  localparam logic [4:0] A_STAT = 5'h00, A_ENAB = 5'h08, A_ACK = 5'h0C, A_CTRL = 5'h1C;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, rd_en;
  logic [4:0] addr;
  logic [31:0] wdata, rdata;
  logic [N-1:0] src;
  logic irq;

  int checks = 0, bad = 0, mon_checks = 0, mon_bad = 0;
  bit finished = 0;
  logic [31:0] expq[$];
  string tagq[$];

  always #2 clk = ~clk;

  intr_hub #(.N_SRC(N), .ADDR_W(5), .LEVEL_MASK(LVL)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_rd_en(rd_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .src_in(src), .irq_out(irq)
  );

  // Monitor: pops one expected read result per sampled read strobe
  initial begin
    bit pend;
    pend = 0;
    forever begin
      @(negedge clk);
      if (pend && expq.size() != 0) begin
        logic [31:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        mon_checks++;
        if (rdata !== e) begin
          mon_bad++;
          $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
        end
      end
      pend = rd_en;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    expq.push_back(e); tagq.push_back(t);
    rd_en = 1; addr = a;
    @(posedge clk); #1;
    rd_en = 0;
    while (expq.size() != 0) @(negedge clk);
  endtask

  task automatic set_src(input logic [N-1:0] v);
    @(posedge clk); #1;
    src = v;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq_out actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks + mon_checks, bad + mon_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0; src = '0;
    step(4);
    rst_n = 1;
    step(1);
    // R1 reset state
    rd(A_STAT, 32'h0, "R1 status");
    rd(A_ENAB, 32'h0, "R1 enable");
    rd(A_CTRL, 32'h0, "R1 ctrl");
    chk_irq(1'b0, "R1 irq");

    // R3 software owns status while hardware enable is clear
    wr(A_STAT, 32'h05);
    rd(A_STAT, 32'h05, "R3 direct write");
    set_src(8'h12);
    step(2);
    rd(A_STAT, 32'h05, "R3 pins ignored");
    wr(A_ACK, 32'h01);
    rd(A_STAT, 32'h04, "R8 ack clears");
    rd(A_ACK, 32'h0, "R2 ack reads zero");
    rd(5'h04, 32'h0, "R2 unmapped reads zero");
    wr(A_STAT, 32'hFFFF_FF00);
    rd(A_STAT, 32'h0, "R2 bits above width");
    set_src(8'h00);
    step(1);

    wr(A_ENAB, 32'h0000_01FF);
    rd(A_ENAB, 32'hFF, "R2 enable readback");
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, 32'h3, "R2 ctrl readback");
    chk_irq(1'b0, "R9 nothing pending");

    // R5 edge line
    set_src(8'h01);
    step(1);
    rd(A_STAT, 32'h01, "R5 edge sets");
    step(2);
    chk_irq(1'b1, "R9 irq raised");
    wr(A_ACK, 32'h01);
    rd(A_STAT, 32'h00, "R5 steady high no re-set");
    step(2);
    chk_irq(1'b0, "R9 irq dropped");
    set_src(8'h00);

    // R4 guard
    wr(A_STAT, 32'h08);
    rd(A_STAT, 32'h00, "R4 write ignored");

    // R6 level line
    set_src(8'h10);
    step(1);
    rd(A_STAT, 32'h10, "R6 level sets");
    wr(A_ACK, 32'h10);
    rd(A_STAT, 32'h10, "R6 re-set after ack");
    set_src(8'h00);
    step(2);
    rd(A_STAT, 32'h10, "R7 low keeps bit");
    wr(A_ACK, 32'h10);
    rd(A_STAT, 32'h00, "R8 ack after low");

    // R8 edge in the same cycle as its acknowledge
    set_src(8'h01);
    set_src(8'h00);
    step(1);
    rd(A_STAT, 32'h01, "R5 second edge");
    @(posedge clk); #1;
    wr_en = 1; addr = A_ACK; wdata = 32'h01; src = 8'h01;
    @(posedge clk); #1;
    wr_en = 0;
    rd(A_STAT, 32'h01, "R8 edge beats ack");
    wr(A_ACK, 32'h01);
    set_src(8'h00);
    rd(A_STAT, 32'h00, "R8 cleared");

    // R9 masking
    set_src(8'h04);
    set_src(8'h00);
    step(2);
    chk_irq(1'b1, "R9 bit2 pending");
    wr(A_ENAB, 32'h0B);
    step(2);
    chk_irq(1'b0, "R9 enable masks");
    wr(A_ENAB, 32'hFF);
    step(2);
    chk_irq(1'b1, "R9 enable restored");
    wr(A_CTRL, 32'h2);
    step(2);
    chk_irq(1'b0, "R9 master off");
    wr(A_CTRL, 32'h3);
    step(2);
    chk_irq(1'b1, "R9 master on");

    // R10 clearing hardware enable
    wr(A_CTRL, 32'h1);
    step(2);
    chk_irq(1'b1, "R10 irq kept");
    rd(A_STAT, 32'h04, "R10 status kept");
    set_src(8'h01);
    step(2);
    rd(A_STAT, 32'h04, "R3 edge ignored when disabled");
    set_src(8'h00);
    step(2);
    summary();
  end
endmodule